// File: doc/BRIEF.md
# Signed Doubleword Divide Unit

This block performs 64-bit signed integer division for an integer pipeline. It reads an XO-form divide instruction word along with both operands and the current summary-overflow bit. It returns the quotient rounded toward zero, and it also returns the overflow, summary-overflow and condition-field updates that the instruction calls for. The pipeline starts an operation with `start` while `busy` is low. It collects the result when `done` pulses. No remainder is produced.

There are two cases where no real quotient exists: a zero divisor, and the most negative value divided by minus one. In both cases the unit returns zero and raises no trap. It finds these cases in its setup cycle and finishes early. Every other operation runs a radix-2 restoring loop on the operand magnitudes, one quotient bit per cycle, and then corrects the sign.

The unit decodes the instruction word and reports whether it is the divide-doubleword encoding. It also passes out the two source-register indices and carries the destination index along with the result.

Top module: `sdw_divide_unit`

## Requirements
- R1: `insn_ok` is 1 exactly when instruction bits [31:26] equal 31 and bits [9:1] equal 489. Bit [10] is the overflow-enable flag, bit [0] is the record flag and bits [25:21] are the destination index. `ra_idx` shows bits [20:16] and `rb_idx` shows bits [15:11]. The destination index of an accepted operation appears on `dst_idx` with its result.
- R2: For defined operands, `quotient` is the signed quotient of `op_a` by `op_b` rounded toward zero.
- R3: A zero divisor yields a quotient of 0 and no trap.
- R4: A dividend of -2^63 with a divisor of -1 yields a quotient of 0.
- R5: With overflow-enable set, `ov_we` and `so_we` are 1, `ov` is 1 exactly in the R3/R4 cases, and `so_out` is `so_in` ORed with `ov`. With overflow-enable clear, `ov_we` and `so_we` are 0.
- R6: With the record flag set, `cr_we` is 1 and `cr0` = {negative, positive, zero, summary-overflow} in bits 3..0. The three compare bits come from the full 64-bit quotient. Bit 0 carries the summary-overflow value after any R5 update. With the record flag clear, `cr_we` is 0.
- R7: `done` rises 66 clock edges after the accepting edge for a normal operation, and 2 edges after it for an R3/R4 case.
- R8: `busy` is 1 from the accepting edge until `done`. A `start` seen while `busy` is high is ignored.
- R9: `done` lasts one cycle. The quotient, flags, write enables and `dst_idx` hold their values until the next `done`.
- R10: A `start` with `insn_ok` low is ignored, and `busy` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a divide |
| insn | input | 32 | Instruction word |
| op_a | input | 64 | Dividend |
| op_b | input | 64 | Divisor |
| so_in | input | 1 | Current summary-overflow bit |
| insn_ok | output | 1 | Instruction word is the divide encoding |
| ra_idx | output | 5 | Dividend register index |
| rb_idx | output | 5 | Divisor register index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result pulse |
| quotient | output | 64 | Signed quotient |
| dst_idx | output | 5 | Destination register index of the result |
| ov_we | output | 1 | Overflow bit write enable |
| ov | output | 1 | New overflow bit |
| so_we | output | 1 | Summary-overflow write enable |
| so_out | output | 1 | New summary-overflow bit |
| cr_we | output | 1 | Condition field write enable |
| cr0 | output | 4 | New condition field |

## Verification
A wrong iteration count or a stuck state shows up as a change in latency. The bench therefore measures the accept-to-`done` distance on every operation, so a slip of even one cycle is caught at the first result. A defect in the shift and subtract step, or in the sign correction, corrupts one or more quotient bits. That shows as a wrong `quotient` when the operation ends, and the cases chosen include negative dividends with remainders and ±1 divisors. If a flag were latched at the wrong time, for example the summary-overflow input or the overflow condition, the error would appear in `so_out`, `ov` or `cr0` bit 0 at that same `done`.

// File: rtl/sdiv_pkg.sv
`timescale 1ns/1ps
package sdiv_pkg;
    localparam int unsigned PRIM_OP = 31;
    localparam int unsigned EXT_OP  = 489;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ITER  = 2'd2,
        ST_FIN   = 2'd3
    } dv_state_e;

    typedef struct packed {
        logic       ok;
        logic       oe;
        logic       rc;
        logic [4:0] dst;
        logic [4:0] ra;
        logic [4:0] rb;
    } xo_fields_t;
endpackage

// File: rtl/xo_decode.sv
`timescale 1ns/1ps
module xo_decode
    import sdiv_pkg::*;
(
    input  logic [31:0] insn,
    output xo_fields_t  fld
);
    always_comb begin
        fld.ok  = (insn[31:26] == 6'(PRIM_OP)) && (insn[9:1] == 9'(EXT_OP));
        fld.dst = insn[25:21];
        fld.ra  = insn[20:16];
        fld.rb  = insn[15:11];
        fld.oe  = insn[10];
        fld.rc  = insn[0];
    end
endmodule

// File: rtl/sdiv_step.sv
`timescale 1ns/1ps
// One restoring iteration: shift the next dividend bit into the partial
// remainder, subtract the divisor when it fits, shift the quotient bit in.
module sdiv_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] rem,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem_nx,
    output logic [W-1:0] dvd_nx
);
    logic [W:0] trial;
    logic       fits;

    always_comb begin
        trial  = {rem, dvd[W-1]} - {1'b0, dvs};
        fits   = ~trial[W];
        rem_nx = fits ? trial[W-1:0] : {rem[W-2:0], dvd[W-1]};
        dvd_nx = {dvd[W-2:0], fits};
    end
endmodule

// File: rtl/sdiv_flags.sv
`timescale 1ns/1ps
module sdiv_flags #(
    parameter int W = 64
) (
    input  logic [W-1:0] quo,
    input  logic         ovf,
    input  logic         oe,
    input  logic         rc,
    input  logic         so_prev,
    output logic         ov_we,
    output logic         ov,
    output logic         so_we,
    output logic         so_new,
    output logic         cr_we,
    output logic [3:0]   cr
);
    logic is_neg, is_zero;

    always_comb begin
        is_neg  = quo[W-1];
        is_zero = (quo == '0);
        ov_we   = oe;
        ov      = ovf;
        so_we   = oe;
        so_new  = so_prev | (oe & ovf);
        cr_we   = rc;
        cr      = {is_neg, ~is_neg & ~is_zero, is_zero, so_new};
    end
endmodule

// File: rtl/sdw_divide_unit.sv
`timescale 1ns/1ps
module sdw_divide_unit
    import sdiv_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [31:0]  insn,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         so_in,
    output logic         insn_ok,
    output logic [4:0]   ra_idx,
    output logic [4:0]   rb_idx,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [4:0]   dst_idx,
    output logic         ov_we,
    output logic         ov,
    output logic         so_we,
    output logic         so_out,
    output logic         cr_we,
    output logic [3:0]   cr0
);
    localparam int          CW       = $clog2(W + 1);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [CW-1:0] LAST_IT = CW'(W - 1);

    typedef struct packed {
        dv_state_e   st;
        logic [CW-1:0] cnt;
        logic [W-1:0] a;      // dividend, then magnitude/quotient shift reg
        logic [W-1:0] b;      // divisor, then its magnitude
        logic [W-1:0] rem;
        logic         neg;
        logic         ovf;
        logic         oe;
        logic         rc;
        logic         so;
        logic [4:0]   dst;
        logic         done;
        logic [W-1:0] res;
        logic [4:0]   dst_o;
        logic         ov_we;
        logic         ov;
        logic         so_we;
        logic         so_o;
        logic         cr_we;
        logic [3:0]   cr;
    } regs_t;

    regs_t        r_q, r_d;
    xo_fields_t   dec;
    logic [W-1:0] step_rem, step_dvd, fin_quo;
    logic         setup_ovf;
    logic         f_ov_we, f_ov, f_so_we, f_so, f_cr_we;
    logic [3:0]   f_cr;

    xo_decode u_dec (
        .insn (insn),
        .fld  (dec)
    );

    sdiv_step #(.W(W)) u_step (
        .rem    (r_q.rem),
        .dvd    (r_q.a),
        .dvs    (r_q.b),
        .rem_nx (step_rem),
        .dvd_nx (step_dvd)
    );

    assign fin_quo = r_q.ovf ? '0 : (r_q.neg ? (W'(0) - r_q.a) : r_q.a);

    sdiv_flags #(.W(W)) u_flags (
        .quo     (fin_quo),
        .ovf     (r_q.ovf),
        .oe      (r_q.oe),
        .rc      (r_q.rc),
        .so_prev (r_q.so),
        .ov_we   (f_ov_we),
        .ov      (f_ov),
        .so_we   (f_so_we),
        .so_new  (f_so),
        .cr_we   (f_cr_we),
        .cr      (f_cr)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        setup_ovf = (r_q.b == '0) || ((r_q.a == MOST_NEG) && (r_q.b == '1));
        unique case (r_q.st)
            ST_IDLE: begin
                if (start && dec.ok) begin
                    r_d.st  = ST_SETUP;
                    r_d.a   = op_a;
                    r_d.b   = op_b;
                    r_d.oe  = dec.oe;
                    r_d.rc  = dec.rc;
                    r_d.so  = so_in;
                    r_d.dst = dec.dst;
                end
            end
            ST_SETUP: begin
                r_d.neg = r_q.a[W-1] ^ r_q.b[W-1];
                r_d.ovf = setup_ovf;
                r_d.a   = r_q.a[W-1] ? (W'(0) - r_q.a) : r_q.a;
                r_d.b   = r_q.b[W-1] ? (W'(0) - r_q.b) : r_q.b;
                r_d.rem = '0;
                r_d.cnt = '0;
                r_d.st  = setup_ovf ? ST_FIN : ST_ITER;
            end
            ST_ITER: begin
                r_d.a   = step_dvd;
                r_d.rem = step_rem;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST_IT) begin
                    r_d.st = ST_FIN;
                end
            end
            ST_FIN: begin
                r_d.st    = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.res   = fin_quo;
                r_d.dst_o = r_q.dst;
                r_d.ov_we = f_ov_we;
                r_d.ov    = f_ov;
                r_d.so_we = f_so_we;
                r_d.so_o  = f_so;
                r_d.cr_we = f_cr_we;
                r_d.cr    = f_cr;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign insn_ok  = dec.ok;
    assign ra_idx   = dec.ra;
    assign rb_idx   = dec.rb;
    assign busy     = (r_q.st != ST_IDLE);
    assign done     = r_q.done;
    assign quotient = r_q.res;
    assign dst_idx  = r_q.dst_o;
    assign ov_we    = r_q.ov_we;
    assign ov       = r_q.ov;
    assign so_we    = r_q.so_we;
    assign so_out   = r_q.so_o;
    assign cr_we    = r_q.cr_we;
    assign cr0      = r_q.cr;
endmodule

// File: rtl/sdw_divide_chk.sv
`timescale 1ns/1ps
module sdw_divide_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         insn_ok,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] quotient,
    input logic         ov_we,
    input logic         ov,
    input logic         so_we,
    input logic         so_out,
    input logic         cr_we,
    input logic [3:0]   cr0
);
    AST_OVF_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        done && ov_we && ov |-> quotient == '0); // R3
    AST_SO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done && so_we && ov |-> so_out); // R5
    AST_CR_SO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        done && cr_we && so_we |-> cr0[0] == so_out); // R6
    AST_CR_ONE_RELATION: assert property (@(posedge clk) disable iff (!rst_n)
        done && cr_we |-> $countones(cr0[3:1]) == 1); // R6
    AST_CR_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done && cr_we |-> (cr0[3] == quotient[W-1]) && (cr0[1] == (quotient == '0))); // R6
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start && insn_ok && !busy |=> busy); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R9
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(quotient)); // R9
    AST_BAD_WORD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        start && !insn_ok && !busy |=> !busy); // R10
endmodule

bind sdw_divide_unit sdw_divide_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .insn_ok  (insn_ok),
    .busy     (busy),
    .done     (done),
    .quotient (quotient),
    .ov_we    (ov_we),
    .ov       (ov),
    .so_we    (so_we),
    .so_out   (so_out),
    .cr_we    (cr_we),
    .cr0      (cr0)
);

// File: tb/tb_sdw_divide_unit.sv
`timescale 1ns/1ps
module tb_sdw_divide_unit;
    localparam longint MINV = 64'sh8000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        so_in = 1'b0;
    logic        insn_ok, busy, done, ov_we, ov, so_we, so_out, cr_we;
    logic [4:0]  ra_idx, rb_idx, dst_idx;
    logic [63:0] quotient;
    logic [3:0]  cr0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sdw_divide_unit #(.W(64)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .insn(insn),
        .op_a(op_a), .op_b(op_b), .so_in(so_in),
        .insn_ok(insn_ok), .ra_idx(ra_idx), .rb_idx(rb_idx),
        .busy(busy), .done(done), .quotient(quotient), .dst_idx(dst_idx),
        .ov_we(ov_we), .ov(ov), .so_we(so_we), .so_out(so_out),
        .cr_we(cr_we), .cr0(cr0)
    );

    function automatic logic [31:0] mk_insn(input logic oe, input logic rc,
                                            input logic [4:0] dst, input logic [8:0] xo);
        return {6'd31, dst, 5'd3, 5'd4, oe, xo, rc};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_div(input longint a, input longint b, input logic oe,
                          input logic rc, input logic so, input logic [4:0] dst);
        logic   ovfx, so_x;
        longint q_x;
        logic [63:0] held;
        int n;
        ovfx = (b == 0) || (a == MINV && b == -1);
        q_x  = ovfx ? 64'sd0 : a / b;
        so_x = so | (oe & ovfx);
        @(negedge clk);
        start = 1'b1; insn = mk_insn(oe, rc, dst, 9'd489);
        op_a = a; op_b = b; so_in = so;
        @(negedge clk);
        start = 1'b0; op_a = '0; op_b = '0; so_in = 1'b0;
        n = 1;
        chk("R8 busy after accept", {63'd0, busy}, 64'd1);
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R7 latency", 64'(n - 1), ovfx ? 64'd2 : 64'd66);
        if (b == 0) chk("R3 zero divisor", quotient, 64'd0);
        else if (ovfx) chk("R4 min by -1", quotient, 64'd0);
        else chk("R2 quotient", quotient, q_x);
        chk("R1 dst", {59'd0, dst_idx}, {59'd0, dst});
        chk("R5 ov_we", {63'd0, ov_we}, {63'd0, oe});
        chk("R5 so_we", {63'd0, so_we}, {63'd0, oe});
        if (oe) begin
            chk("R5 ov", {63'd0, ov}, {63'd0, ovfx});
            chk("R5 so", {63'd0, so_out}, {63'd0, so_x});
        end
        chk("R6 cr_we", {63'd0, cr_we}, {63'd0, rc});
        if (rc)
            chk("R6 cr0", {60'd0, cr0},
                {60'd0, q_x < 0, q_x > 0, q_x == 0, so_x});
        held = quotient;
        @(negedge clk);
        chk("R9 done one cycle", {63'd0, done}, 64'd0);
        chk("R9 result held", quotient, held);
    endtask

    task automatic t_reset();
        chk("R8 reset busy", {63'd0, busy}, 64'd0);
        chk("R9 reset done", {63'd0, done}, 64'd0);
        chk("R6 reset cr_we", {63'd0, cr_we}, 64'd0);
        chk("R2 reset quotient", quotient, 64'd0);
    endtask

    task automatic t_decode();
        @(negedge clk);
        insn = mk_insn(1'b1, 1'b1, 5'd9, 9'd489);
        #1;
        chk("R1 valid word", {63'd0, insn_ok}, 64'd1);
        chk("R1 ra field", {59'd0, ra_idx}, 64'd3);
        chk("R1 rb field", {59'd0, rb_idx}, 64'd4);
        insn = mk_insn(1'b0, 1'b0, 5'd9, 9'd457);
        #1;
        chk("R1 other xo", {63'd0, insn_ok}, 64'd0);
        insn = {6'd30, 26'h0_0003d2};
        #1;
        chk("R1 other primary", {63'd0, insn_ok}, 64'd0);
        insn = 32'h7c00_03d2;
        #1;
        chk("R1 bare word", {63'd0, insn_ok}, 64'd1);
    endtask

    task automatic t_overflow_cases();
        do_div(64'sd12345, 64'sd0, 1'b1, 1'b1, 1'b0, 5'd1);
        do_div(-64'sd7, 64'sd0, 1'b1, 1'b0, 1'b1, 5'd2);
        do_div(MINV, -64'sd1, 1'b1, 1'b1, 1'b0, 5'd3);
        do_div(MINV, -64'sd1, 1'b0, 1'b1, 1'b0, 5'd4);
        do_div(64'sd0, 64'sd0, 1'b0, 1'b0, 1'b0, 5'd5);
    endtask

    task automatic t_unit_divisors();
        do_div(MINV, 64'sd1, 1'b1, 1'b1, 1'b0, 5'd6);
        do_div(64'sh7fff_ffff_ffff_ffff, -64'sd1, 1'b1, 1'b1, 1'b0, 5'd7);
        do_div(-64'sd99, -64'sd1, 1'b0, 1'b1, 1'b0, 5'd8);
        do_div(64'sd0, -64'sd1, 1'b0, 1'b1, 1'b1, 5'd9);
        do_div(MINV, 64'sd2, 1'b0, 1'b1, 1'b0, 5'd10);
    endtask

    task automatic t_neg_remainder();
        do_div(-64'sd7, 64'sd2, 1'b0, 1'b1, 1'b0, 5'd11);
        do_div(-64'sd7, -64'sd2, 1'b0, 1'b1, 1'b0, 5'd12);
        do_div(64'sd7, -64'sd2, 1'b0, 1'b1, 1'b0, 5'd13);
        do_div(-64'sd1, 64'sd3, 1'b0, 1'b1, 1'b0, 5'd14);
        do_div(MINV, 64'sd3, 1'b0, 1'b1, 1'b0, 5'd15);
    endtask

    task automatic t_flag_combos();
        for (int k = 0; k < 4; k++) begin
            do_div(-64'sd1000, 64'sd7, k[0], k[1], 1'b1, 5'(k + 16));
            do_div(64'sd5, 64'sd0, k[0], k[1], 1'b1, 5'(k + 20));
        end
    endtask

    task automatic t_random();
        for (int k = 0; k < 24; k++) begin
            longint a, b;
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            b = b >>> ($urandom % 62);
            do_div(a, b, 1'($urandom), 1'($urandom), 1'($urandom), 5'($urandom));
        end
    endtask

    task automatic t_busy_ignore();
        int n;
        @(negedge clk);
        start = 1'b1; insn = mk_insn(1'b0, 1'b0, 5'd30, 9'd489);
        op_a = 64'd100; op_b = 64'd7;
        @(negedge clk);
        op_a = 64'd1; op_b = 64'd1; insn = mk_insn(1'b0, 1'b0, 5'd31, 9'd489);
        repeat (5) @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R8 first op result", quotient, 64'd14);
        chk("R8 first op dst", {59'd0, dst_idx}, 64'd30);
        @(negedge clk);
        chk("R8 no queued op", {63'd0, busy}, 64'd0);
    endtask

    task automatic t_bad_insn();
        @(negedge clk);
        start = 1'b1; insn = mk_insn(1'b1, 1'b1, 5'd2, 9'd490);
        op_a = 64'd9; op_b = 64'd3;
        @(negedge clk);
        start = 1'b0;
        chk("R10 busy stays low", {63'd0, busy}, 64'd0);
        repeat (3) @(negedge clk);
        chk("R10 no done", {63'd0, done}, 64'd0);
        chk("R10 busy still low", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_decode();
        t_overflow_cases();
        t_unit_divisors();
        t_neg_remainder();
        t_flag_combos();
        t_random();
        t_busy_ignore();
        t_bad_insn();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule